// File: doc/BRIEF.md
# ADC Sample-and-Convert Sequencer

This block sets the timing of a successive-approximation ADC front end. A small register bus holds four settings: a sample length in clock cycles, a conversion-length unit, and the first and last channels of a scan. A one-cycle start pulse launches a scan. For each channel in the scan, the block drives the channel number onto the input multiplexer. It then holds a sample enable for the programmed length and a convert enable for the derived conversion length. Finally it waits for the converter's result strobe and presents the captured result with its channel number.

The comparator and DAC are not part of the block. They appear as a result bus with a valid strobe. A strobe outside the result-wait window is ignored. While a scan runs, configuration writes and further start pulses are dropped, so every channel of a scan uses the same settings. The last capture of a scan comes with a one-cycle done pulse, and busy falls at the same time.

Top module: `adc_seq_ctrl`

## Requirements
- R1: The register map has four words. Address 0 holds the sample length in bits 9:0. Address 1 holds the conversion unit in bits 7:0. Address 2 holds the first channel in bits 12:8. Address 3 holds the last channel in bits 12:8. All other bits read zero and ignore writes, including bits 15:13 of the channel words.
- R2: After reset the sample length reads 44 (binary 0000101100), the conversion unit reads 2, both channel fields read 0, and busy, done and cap_valid are low.
- R3: samp_en is high for exactly the programmed sample length in clock cycles. A setting of 0 behaves as 1 cycle. The first sample cycle is the cycle after the start pulse is registered.
- R4: conv_en rises in the cycle after the last sample cycle. It stays high for (conversion unit × 10 + 4) cycles.
- R5: After the convert phase the block waits for res_valid. The result is registered on cap_data and cap_chan, with cap_valid high for one cycle, in the cycle after res_valid. A res_valid outside the wait is ignored.
- R6: Channels are scanned in ascending order from the first channel to the last channel inclusive. If the last channel is not above the first, only the first channel is converted.
- R7: mux_sel carries the current channel number throughout its sample, convert and wait phases.
- R8: busy is high from the cycle after an accepted start until the cycle in which the last result appears. A one-cycle done pulse coincides with that last cap_valid.
- R9: A start pulse while busy has no effect on the running scan.
- R10: Register writes that arrive while busy are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| start | input | 1 | Scan start pulse |
| res_valid | input | 1 | Converter result strobe |
| res_data | input | 10 | Converter result |
| busy | output | 1 | Scan in progress |
| samp_en | output | 1 | Sample enable |
| conv_en | output | 1 | Convert enable |
| mux_sel | output | 5 | Current channel |
| cap_valid | output | 1 | Captured result valid (one cycle) |
| cap_data | output | 10 | Captured result |
| cap_chan | output | 5 | Channel of the captured result |
| done | output | 1 | Scan complete (one cycle) |

## Verification
The bench targets a zero sample length, and a design that loads the raw value would hang or skip the sample phase. It also covers a last channel below the first, where a naive increment would wrap through all 32 channels. Writes and start pulses are issued in the middle of a scan, so a design that honours them would change the channel range or restart the timing. Result strobes are injected during sampling and conversion, and a design that accepts them early would capture a result too soon. The longest conversion setting checks that the phase counter is wide enough not to truncate the 2554-cycle window.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SAMP = 2'd1,
        PH_CONV = 2'd2,
        PH_WAIT = 2'd3
    } phase_e;

endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs #(
    parameter int REG_W  = 16,
    parameter int ST_W   = 10,
    parameter int CT_W   = 8,
    parameter int CH_W   = 5,
    parameter int CH_LSB = 8,
    parameter int ST_RST = 44,
    parameter int CT_RST = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              busy,
    output logic [ST_W-1:0]   st,
    output logic [CT_W-1:0]   ct,
    output logic [CH_W-1:0]   first_ch,
    output logic [CH_W-1:0]   last_ch,
    output logic [REG_W-1:0]  rdata
);

    typedef struct packed {
        logic [ST_W-1:0] st;
        logic [CT_W-1:0] ct;
        logic [CH_W-1:0] first_ch;
        logic [CH_W-1:0] last_ch;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en && !busy) begin
            case (addr)
                2'd0:    cfg_d.st       = wdata[ST_W-1:0];
                2'd1:    cfg_d.ct       = wdata[CT_W-1:0];
                2'd2:    cfg_d.first_ch = wdata[CH_LSB +: CH_W];
                default: cfg_d.last_ch  = wdata[CH_LSB +: CH_W];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.st       <= ST_W'(ST_RST);
            cfg_q.ct       <= CT_W'(CT_RST);
            cfg_q.first_ch <= '0;
            cfg_q.last_ch  <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            2'd0:    rdata[ST_W-1:0]       = cfg_q.st;
            2'd1:    rdata[CT_W-1:0]       = cfg_q.ct;
            2'd2:    rdata[CH_LSB +: CH_W] = cfg_q.first_ch;
            default: rdata[CH_LSB +: CH_W] = cfg_q.last_ch;
        endcase
    end

    assign st       = cfg_q.st;
    assign ct       = cfg_q.ct;
    assign first_ch = cfg_q.first_ch;
    assign last_ch  = cfg_q.last_ch;

    // R10: settings hold still across any cycle in which a scan runs
    a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cfg_q));

endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

    // R3: an expired phase counter never wraps
    a_r3_timer_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && !load) |=> (cnt_q == '0));

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int ST_W   = 10,
    parameter int CT_W   = 8,
    parameter int CH_W   = 5,
    parameter int DATA_W = 10,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ST_W-1:0]   st,
    input  logic [CT_W-1:0]   ct,
    input  logic [CH_W-1:0]   first_ch,
    input  logic [CH_W-1:0]   last_ch,
    input  logic              res_valid,
    input  logic [DATA_W-1:0] res_data,
    input  logic              tmr_zero,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_val,
    output logic              busy,
    output logic              samp_en,
    output logic              conv_en,
    output logic [CH_W-1:0]   mux_sel,
    output logic              cap_valid,
    output logic [DATA_W-1:0] cap_data,
    output logic [CH_W-1:0]   cap_chan,
    output logic              done
);

    typedef struct packed {
        phase_e            phase;
        logic [CH_W-1:0]   ch;
        logic              cap_valid;
        logic [DATA_W-1:0] cap_data;
        logic [CH_W-1:0]   cap_chan;
        logic              done;
    } seq_t;

    seq_t s_d, s_q;

    logic [CNT_W-1:0] samp_load;
    logic [CNT_W-1:0] conv_load;

    // counter holds (length - 1); a zero sample setting still gives one cycle
    assign samp_load = (st == '0) ? '0 : (CNT_W'(st) - CNT_W'(1));
    assign conv_load = (CNT_W'(ct) * CNT_W'(10)) + CNT_W'(3);

    always_comb begin
        s_d           = s_q;
        s_d.cap_valid = 1'b0;
        s_d.done      = 1'b0;
        tmr_load      = 1'b0;
        tmr_val       = '0;
        case (s_q.phase)
            PH_IDLE: begin
                if (start) begin
                    s_d.phase = PH_SAMP;
                    s_d.ch    = first_ch;
                    tmr_load  = 1'b1;
                    tmr_val   = samp_load;
                end
            end
            PH_SAMP: begin
                if (tmr_zero) begin
                    s_d.phase = PH_CONV;
                    tmr_load  = 1'b1;
                    tmr_val   = conv_load;
                end
            end
            PH_CONV: begin
                if (tmr_zero)
                    s_d.phase = PH_WAIT;
            end
            default: begin
                if (res_valid) begin
                    s_d.cap_valid = 1'b1;
                    s_d.cap_data  = res_data;
                    s_d.cap_chan  = s_q.ch;
                    if (s_q.ch >= last_ch) begin
                        s_d.phase = PH_IDLE;
                        s_d.done  = 1'b1;
                    end else begin
                        s_d.phase = PH_SAMP;
                        s_d.ch    = s_q.ch + CH_W'(1);
                        tmr_load  = 1'b1;
                        tmr_val   = samp_load;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.phase     <= PH_IDLE;
            s_q.ch        <= '0;
            s_q.cap_valid <= 1'b0;
            s_q.cap_data  <= '0;
            s_q.cap_chan  <= '0;
            s_q.done      <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy      = (s_q.phase != PH_IDLE);
    assign samp_en   = (s_q.phase == PH_SAMP);
    assign conv_en   = (s_q.phase == PH_CONV);
    assign mux_sel   = s_q.ch;
    assign cap_valid = s_q.cap_valid;
    assign cap_data  = s_q.cap_data;
    assign cap_chan  = s_q.cap_chan;
    assign done      = s_q.done;

    // R4: the end of sampling hands straight over to conversion
    a_r4_conv_after_samp: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_SAMP && tmr_zero) |=> (s_q.phase == PH_CONV));

    // R5: a capture only follows a strobe seen in the wait phase
    a_r5_cap_from_wait: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cap_valid |-> $past(s_q.phase == PH_WAIT && res_valid));

    // R8: the done pulse leaves the sequencer idle and comes with a capture
    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |-> (s_q.phase == PH_IDLE && s_q.cap_valid));

    // R6: the active channel never passes the last one unless it is the first
    a_r6_chan_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase != PH_IDLE) |-> (s_q.ch <= last_ch || s_q.ch == first_ch));

    // R9: a start during sampling leaves channel and phase alone
    a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_SAMP && !tmr_zero && start) |=>
            (s_q.phase == PH_SAMP && $stable(s_q.ch)));

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
    parameter int REG_W  = 16,
    parameter int ST_W   = 10,
    parameter int CT_W   = 8,
    parameter int CH_W   = 5,
    parameter int CH_LSB = 8,
    parameter int DATA_W = 10,
    parameter int ST_RST = 44,
    parameter int CT_RST = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              start,
    input  logic              res_valid,
    input  logic [DATA_W-1:0] res_data,
    output logic              busy,
    output logic              samp_en,
    output logic              conv_en,
    output logic [CH_W-1:0]   mux_sel,
    output logic              cap_valid,
    output logic [DATA_W-1:0] cap_data,
    output logic [CH_W-1:0]   cap_chan,
    output logic              done
);

    localparam int CONV_MAX = ((2 ** CT_W) - 1) * 10 + 4;
    localparam int CONV_W   = $clog2(CONV_MAX + 1);
    localparam int CNT_W    = (CONV_W > ST_W) ? CONV_W : ST_W;

    logic [ST_W-1:0]  st;
    logic [CT_W-1:0]  ct;
    logic [CH_W-1:0]  first_ch;
    logic [CH_W-1:0]  last_ch;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;

    adc_seq_regs #(
        .REG_W (REG_W), .ST_W (ST_W), .CT_W (CT_W), .CH_W (CH_W),
        .CH_LSB(CH_LSB), .ST_RST(ST_RST), .CT_RST(CT_RST)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .busy    (busy),
        .st      (st),
        .ct      (ct),
        .first_ch(first_ch),
        .last_ch (last_ch),
        .rdata   (reg_rdata)
    );

    adc_seq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .zero    (tmr_zero)
    );

    adc_seq_fsm #(
        .ST_W(ST_W), .CT_W(CT_W), .CH_W(CH_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .st       (st),
        .ct       (ct),
        .first_ch (first_ch),
        .last_ch  (last_ch),
        .res_valid(res_valid),
        .res_data (res_data),
        .tmr_zero (tmr_zero),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .busy     (busy),
        .samp_en  (samp_en),
        .conv_en  (conv_en),
        .mux_sel  (mux_sel),
        .cap_valid(cap_valid),
        .cap_data (cap_data),
        .cap_chan (cap_chan),
        .done     (done)
    );

    // R8: busy drops in exactly the cycle that done is raised
    a_r8_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

endmodule

// File: tb/adc_seq_ctrl_tb.sv
`timescale 1ns/100ps
module adc_seq_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        start = 1'b0;
    logic        res_valid = 1'b0;
    logic [9:0]  res_data = '0;
    logic        busy, samp_en, conv_en, cap_valid, done;
    logic [4:0]  mux_sel, cap_chan;
    logic [9:0]  cap_data;

    always #2 clk = ~clk;

    adc_seq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .start(start),
        .res_valid(res_valid), .res_data(res_data), .busy(busy),
        .samp_en(samp_en), .conv_en(conv_en), .mux_sel(mux_sel),
        .cap_valid(cap_valid), .cap_data(cap_data), .cap_chan(cap_chan),
        .done(done)
    );

    int n_cmp = 0, n_bad = 0, n_caps = 0;
    bit running = 0, finished = 0;

    // behavioural reference state
    int m_st, m_ct, m_first, m_last, m_mode, m_rem, m_ch;
    int m_capv, m_capd, m_capc, m_done;
    bit m_was_idle;

    int resp_delay = 0, wcnt = 0, seq = 0;
    bit spurious = 0;

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int samp_len(int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int exp_rdata(int a);
        case (a)
            0: return m_st;
            1: return m_ct;
            2: return m_first << 8;
            default: return m_last << 8;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 44; m_ct = 2; m_first = 0; m_last = 0;
            m_mode = 0; m_rem = 0; m_ch = 0;
            m_capv = 0; m_capd = 0; m_capc = 0; m_done = 0;
        end else begin
            m_was_idle = (m_mode == 0);
            m_capv = 0; m_done = 0;
            case (m_mode)
                0: if (start) begin m_mode = 1; m_ch = m_first; m_rem = samp_len(m_st); end
                1: begin m_rem--; if (m_rem == 0) begin m_mode = 2; m_rem = m_ct * 10 + 4; end end
                2: begin m_rem--; if (m_rem == 0) m_mode = 3; end
                default: if (res_valid) begin
                    m_capv = 1; m_capd = int'(res_data); m_capc = m_ch;
                    if (m_ch >= m_last) begin m_mode = 0; m_done = 1; end
                    else begin m_ch++; m_mode = 1; m_rem = samp_len(m_st); end
                end
            endcase
            if (reg_wr && m_was_idle) begin
                case (reg_addr)
                    2'd0: m_st = int'(reg_wdata) & 1023;
                    2'd1: m_ct = int'(reg_wdata) & 255;
                    2'd2: m_first = (int'(reg_wdata) >> 8) & 31;
                    default: m_last = (int'(reg_wdata) >> 8) & 31;
                endcase
            end
        end
    end

    // converter stand-in, driven just after the edge
    always @(posedge clk) begin
        #1;
        if (m_mode == 3) begin
            if (wcnt == resp_delay) begin
                res_valid = 1'b1;
                res_data  = 10'((m_ch * 41 + seq) % 1024);
                seq++;
            end else begin
                res_valid = 1'b0;
            end
            wcnt++;
        end else begin
            wcnt = 0;
            res_valid = spurious && (m_mode == 1 || m_mode == 2);
            res_data  = 10'h2aa;
        end
    end

    // per-cycle comparison against the model, between edges
    always @(negedge clk) begin
        if (running && rst_n) begin
            chk("R8 busy", int'(busy), int'(m_mode != 0));
            chk("R3 samp_en", int'(samp_en), int'(m_mode == 1));
            chk("R4 conv_en", int'(conv_en), int'(m_mode == 2));
            chk("R7 mux_sel", int'(mux_sel), m_ch);
            chk("R5 cap_valid", int'(cap_valid), m_capv);
            chk("R5 cap_data", int'(cap_data), m_capd);
            chk("R6 cap_chan", int'(cap_chan), m_capc);
            chk("R8 done", int'(done), m_done);
            chk("R1 reg_rdata", int'(reg_rdata), exp_rdata(int'(reg_addr)));
            if (cap_valid) n_caps++;
        end
    end

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic wr(int a, int d);
        reg_wr = 1'b1; reg_addr = 2'(a); reg_wdata = 16'(d);
        cyc();
        reg_wr = 1'b0;
    endtask

    task automatic go();
        start = 1'b1;
        cyc();
        start = 1'b0;
    endtask

    task automatic wait_idle();
        while (m_mode != 0) cyc();
        cyc();
    endtask

    task automatic rd(int a, int exp, string tag);
        reg_addr = 2'(a);
        @(negedge clk); #0.5;
        chk(tag, int'(reg_rdata), exp);
        cyc();
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL R8 watchdog actual=hung expected=idle");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;
        running = 1;
        // R2: reset values
        chk("R2 busy after reset", int'(busy), 0);
        chk("R2 cap_valid after reset", int'(cap_valid), 0);
        rd(0, 44, "R2 sample length reset");
        rd(1, 2, "R2 conversion unit reset");
        rd(2, 0, "R2 first channel reset");
        rd(3, 0, "R2 last channel reset");

        // default single-channel scan
        n_caps = 0;
        go(); wait_idle();
        chk("R6 single channel capture count", n_caps, 1);

        // R6: ascending scan 3..6 with delayed results
        wr(0, 5); wr(1, 1); wr(2, 3 << 8); wr(3, 6 << 8);
        resp_delay = 2; n_caps = 0;
        go(); wait_idle();
        chk("R6 ascending capture count", n_caps, 4);

        // R3: zero sample setting, shortest conversion
        wr(0, 0); wr(1, 0); wr(2, 7 << 8); wr(3, 7 << 8);
        resp_delay = 0;
        go(); wait_idle();

        // R1: reserved bits read zero
        wr(2, 16'hFFFF);
        rd(2, 16'h1F00, "R1 first channel masks bits 15:13");
        wr(0, 16'hFFFF);
        rd(0, 16'h03FF, "R1 sample field masks upper bits");
        wr(1, 16'hFFFF);
        rd(1, 16'h00FF, "R1 conversion field masks upper bits");

        // R6: last below first converts the first only
        wr(0, 3); wr(1, 0); wr(2, 9 << 8); wr(3, 4 << 8);
        n_caps = 0;
        go(); wait_idle();
        chk("R6 reversed range capture count", n_caps, 1);

        // R10 and R9: writes and start in mid-scan
        wr(2, 1 << 8); wr(3, 3 << 8); wr(0, 3);
        resp_delay = 1; n_caps = 0;
        go();
        wr(2, 20 << 8);
        wr(0, 100);
        cyc();
        go();
        repeat (3) cyc();
        go();
        wait_idle();
        chk("R9 restart ignored capture count", n_caps, 3);
        rd(2, 1 << 8, "R10 first channel kept");
        rd(0, 3, "R10 sample length kept");

        // R5: stray strobes during sample and convert
        wr(0, 6); wr(1, 1); wr(2, 30 << 8); wr(3, 31 << 8);
        spurious = 1; resp_delay = 3; n_caps = 0;
        go(); wait_idle();
        spurious = 0;
        chk("R5 stray strobe capture count", n_caps, 2);

        // R4: longest conversion window
        wr(1, 255); wr(0, 1); wr(2, 31 << 8); wr(3, 31 << 8);
        resp_delay = 0;
        go(); wait_idle();

        repeat (3) cyc();
        finished = 1;
        summary();
        $finish;
    end

endmodule